// File: doc/BRIEF.md
# Half-Duplex Collision and Heartbeat Generator

This block drives the collision and carrier-sense outputs of a 10 Mb/s transceiver's media-independent interface. It runs on the 10 MHz bit clock, so one clock cycle is one bit time. It takes four inputs: a transmit-busy flag, a receive-valid flag from the squelch logic, a full-duplex mode select and a heartbeat enable. From these it decides when a collision should be reported and when the medium counts as busy.

In half duplex, a collision is the overlap of transmit and receive activity. The overlap has to last seven bit times before the collision output goes high, so short noise bursts during a transmission are filtered out. After that, the collision output stays high until the overlap ends. In full duplex, overlap is normal and never raises the collision output.

When the heartbeat is enabled at the moment transmission ends, a signal-quality-error pulse ten bit times wide appears on the collision output ten bit times after the end of transmission. Carrier sense follows receive activity, and in half duplex it also follows the block's own transmission.

Top module: `col_crs_gen`

## Requirements
- R1: In half duplex (fullDuplex=0), when txActive=1 and rxValid=1 are sampled at 7 consecutive rising edges, col is high after the 7th of those edges and not before.
- R2: With fullDuplex=1, transmit and receive overlap never raises col; only a heartbeat pulse can.
- R3: If the overlap drops before 7 consecutive sampled edges, the persistence count restarts from zero. A later overlap again needs 7 consecutive edges.
- R4: Once raised, col stays high while the overlap is still sampled. It goes low after the first edge at which the overlap is absent, unless a heartbeat pulse is active.
- R5: Call E0 the first rising edge at which txActive=0 after an edge at which it was 1. If hbEnable=1 at E0, col is high after edges E0+10 through E0+19 (10 cycles), and low just before and just after that window.
- R6: If hbEnable=0 at E0, no heartbeat pulse follows that transmission.
- R7: Any edge at which txActive=1 cancels a pending or active heartbeat. col carries no heartbeat after that edge.
- R8: In half duplex, crs is high one cycle after an edge that samples rxValid=1 or txActive=1, and low one cycle after an edge that samples both low.
- R9: In full duplex, crs follows only rxValid, with one cycle of latency. txActive alone leaves crs low.
- R10: Synchronous reset (rst=1 at an edge) clears all counters and the heartbeat, and drives col and crs low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| txActive | input | 1 | Local transmitter is sending |
| rxValid | input | 1 | Squelch logic reports valid receive data |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| hbEnable | input | 1 | Heartbeat enable, sampled when transmission ends |
| col | output | 1 | Collision / heartbeat indication |
| crs | output | 1 | Carrier sense |

## Verification
Every output is registered, so the bench drives inputs on the falling edge and expects the reaction after the next rising edge. It compares col and crs on the following falling edge against a behavioural model that has been advanced by that same rising edge.

Collision onset is due exactly seven edges into an overlap, and release is due one edge after the overlap ends. The heartbeat pulse is due ten edges after the first edge that sees transmission ended, and it lasts ten edges. The directed checks sample at those edge counts, one cycle before each transition and on it.

// File: rtl/colhb_pkg.sv
package colhb_pkg;

  // Strobes passed from the control FSM to the datapath.
  typedef struct packed {
    logic collCond;  // overlap of transmit and receive in half duplex
    logic hbOn;      // heartbeat pulse currently active
  } colStrobe_t;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hbState_t;

endpackage

// File: rtl/colhb_ctrl.sv
module colhb_ctrl
  import colhb_pkg::*;
#(
  parameter int HB_DELAY = 10,
  parameter int HB_WIDTH = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txActive,
  input  logic       rxValid,
  input  logic       fullDuplex,
  input  logic       hbEnable,
  output colStrobe_t strobe
);

  localparam int HB_MAX   = (HB_DELAY > HB_WIDTH) ? HB_DELAY : HB_WIDTH;
  localparam int HB_CNT_W = $clog2(HB_MAX + 1);
  localparam logic [HB_CNT_W-1:0] DELAY_END = HB_CNT_W'(HB_DELAY);
  localparam logic [HB_CNT_W-1:0] WIDTH_END = HB_CNT_W'(HB_WIDTH);
  localparam logic [HB_CNT_W-1:0] CNT_ONE   = HB_CNT_W'(1);

  logic                txPrev;
  logic                txFall;
  hbState_t            hbState, hbStateNext;
  logic [HB_CNT_W-1:0] hbCnt, hbCntNext;

  assign txFall = txPrev & ~txActive;

  always_ff @(posedge clk) begin
    if (rst) txPrev <= 1'b0;
    else     txPrev <= txActive;
  end

  always_comb begin
    hbStateNext = hbState;
    hbCntNext   = hbCnt;
    if (txActive) begin
      // a fresh transmission cancels any pending or running heartbeat
      hbStateNext = HB_IDLE;
      hbCntNext   = '0;
    end else begin
      unique case (hbState)
        HB_IDLE: begin
          if (txFall && hbEnable) begin
            hbStateNext = HB_WAIT;
            hbCntNext   = CNT_ONE;
          end
        end
        HB_WAIT: begin
          if (hbCnt == DELAY_END) begin
            hbStateNext = HB_PULSE;
            hbCntNext   = CNT_ONE;
          end else begin
            hbCntNext = hbCnt + CNT_ONE;
          end
        end
        HB_PULSE: begin
          if (hbCnt == WIDTH_END) begin
            hbStateNext = HB_IDLE;
            hbCntNext   = '0;
          end else begin
            hbCntNext = hbCnt + CNT_ONE;
          end
        end
        default: begin
          hbStateNext = HB_IDLE;
          hbCntNext   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hbState <= HB_IDLE;
      hbCnt   <= '0;
    end else begin
      hbState <= hbStateNext;
      hbCnt   <= hbCntNext;
    end
  end

  assign strobe.collCond = txActive & rxValid & ~fullDuplex;
  assign strobe.hbOn     = (hbState == HB_PULSE);

endmodule

// File: rtl/colhb_dpath.sv
module colhb_dpath
  import colhb_pkg::*;
#(
  parameter int PERSIST_BITS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txActive,
  input  logic       rxValid,
  input  logic       fullDuplex,
  input  colStrobe_t strobe,
  output logic       collOn,
  output logic       col,
  output logic       crs
);

  localparam int PCNT_W = $clog2(PERSIST_BITS + 1);
  localparam logic [PCNT_W-1:0] PERSIST_END = PCNT_W'(PERSIST_BITS);

  logic [PCNT_W-1:0] persistCnt;
  logic              crsReg;

  // Saturating count of consecutive edges with the overlap present.
  always_ff @(posedge clk) begin
    if (rst || !strobe.collCond)   persistCnt <= '0;
    else if (persistCnt != PERSIST_END) persistCnt <= persistCnt + PCNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) crsReg <= 1'b0;
    else     crsReg <= rxValid | (txActive & ~fullDuplex);
  end

  assign collOn = (persistCnt == PERSIST_END);
  assign col    = collOn | strobe.hbOn;
  assign crs    = crsReg;

endmodule

// File: rtl/col_crs_gen.sv
module col_crs_gen
  import colhb_pkg::*;
#(
  parameter int PERSIST_BITS = 7,
  parameter int HB_DELAY     = 10,
  parameter int HB_WIDTH     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic txActive,
  input  logic rxValid,
  input  logic fullDuplex,
  input  logic hbEnable,
  output logic col,
  output logic crs
);

  colStrobe_t strobe;
  logic       collOn;

  colhb_ctrl #(.HB_DELAY(HB_DELAY), .HB_WIDTH(HB_WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .txActive(txActive), .rxValid(rxValid),
    .fullDuplex(fullDuplex), .hbEnable(hbEnable), .strobe(strobe)
  );

  colhb_dpath #(.PERSIST_BITS(PERSIST_BITS)) u_dpath (
    .clk(clk), .rst(rst), .txActive(txActive), .rxValid(rxValid),
    .fullDuplex(fullDuplex), .strobe(strobe), .collOn(collOn),
    .col(col), .crs(crs)
  );

endmodule

// File: rtl/col_crs_gen_chk.sv
module col_crs_gen_chk (
  input logic clk,
  input logic rst,
  input logic txActive,
  input logic rxValid,
  input logic fullDuplex,
  input logic collOn,
  input logic hbOn,
  input logic col,
  input logic crs
);

  AST_COLL_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    collOn |-> $past(txActive && rxValid && !fullDuplex)); // R1

  AST_FD_NO_COLL: assert property (@(posedge clk) disable iff (rst)
    $past(fullDuplex) |-> !collOn); // R2

  AST_COLL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (collOn && !(txActive && rxValid && !fullDuplex)) |=> !collOn); // R4

  AST_COL_SOURCES: assert property (@(posedge clk) disable iff (rst)
    col |-> (collOn || hbOn)); // R4

  AST_HB_CANCEL: assert property (@(posedge clk) disable iff (rst)
    txActive |=> !hbOn); // R7

  AST_CRS_TX_HD: assert property (@(posedge clk) disable iff (rst)
    (txActive && !fullDuplex) |=> crs); // R8

  AST_CRS_FD_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
    (fullDuplex && !rxValid) |=> !crs); // R9

endmodule

bind col_crs_gen col_crs_gen_chk u_chk (
  .clk(clk), .rst(rst), .txActive(txActive), .rxValid(rxValid),
  .fullDuplex(fullDuplex), .collOn(collOn), .hbOn(strobe.hbOn),
  .col(col), .crs(crs)
);

// File: tb/col_crs_gen_tb.sv
`timescale 1ns/1ps
module col_crs_gen_tb;

  localparam int CLK_PERIOD = 100;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx = 1'b0, rx = 1'b0, fd = 1'b0, hb = 1'b0;
  logic col, crs;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  bit seenEdge = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_crs_gen u_dut (
    .clk(clk), .rst(rst), .txActive(tx), .rxValid(rx),
    .fullDuplex(fd), .hbEnable(hb), .col(col), .crs(crs)
  );

  // Behavioural reference: overlap run length, edges since end of transmission.
  int  runLen = 0;
  int  sinceFall = 1000;
  bit  hbArmed = 0;
  bit  txSeen = 0;
  bit  crsExp = 0;
  bit  fdSeen = 0;

  function automatic bit colExp();
    return (runLen >= 7) || (hbArmed && sinceFall >= 10 && sinceFall < 20);
  endfunction

  always @(posedge clk) begin
    seenEdge <= 1;
    if (rst) begin
      runLen = 0; sinceFall = 1000; hbArmed = 0; txSeen = 0; crsExp = 0; fdSeen = 0;
    end else begin
      if (tx && rx && !fd) runLen = (runLen < 7) ? runLen + 1 : 7;
      else                 runLen = 0;
      crsExp = rx || (tx && !fd);
      if (tx) begin
        hbArmed = 0;
      end else if (txSeen) begin
        hbArmed = hb;
        sinceFall = 0;
      end else if (sinceFall < 1000) begin
        sinceFall++;
      end
      txSeen = tx;
      fdSeen = fd;
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (seenEdge && !done) begin
      vectors++;
      if (col !== colExp()) begin
        miscompares++;
        if (fdSeen && runLen == 0 && !(hbArmed && sinceFall >= 10 && sinceFall < 20))
          $display("FAIL R2 col actual=%0b expected=%0b t=%0t", col, colExp(), $time);
        else if (hbArmed && sinceFall >= 9 && sinceFall <= 20)
          $display("FAIL R5 col actual=%0b expected=%0b t=%0t", col, colExp(), $time);
        else
          $display("FAIL R1 col actual=%0b expected=%0b t=%0t", col, colExp(), $time);
      end
      vectors++;
      if (crs !== crsExp) begin
        miscompares++;
        $display("FAIL %s crs actual=%0b expected=%0b t=%0t",
                 fdSeen ? "R9" : "R8", crs, crsExp, $time);
      end
    end
  end

  task automatic step(input bit t, input bit r, input bit f, input bit h, input int n);
    tx = t; rx = r; fd = f; hb = h;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    @(negedge clk);
    rst = 1;
    step(0, 0, 0, 0, 3);
    rst = 0;
    chk("R10 col after reset", col, 1'b0);
    chk("R10 crs after reset", crs, 1'b0);

    // R1 onset after seven overlapped edges
    step(1, 1, 0, 0, 6);
    chk("R1 col before 7th edge", col, 1'b0);
    step(1, 1, 0, 0, 1);
    chk("R1 col on 7th edge", col, 1'b1);
    // R4 held, then released
    step(1, 1, 0, 0, 20);
    chk("R4 col held", col, 1'b1);
    step(0, 0, 0, 0, 1);
    chk("R4 col released", col, 1'b0);
    step(0, 0, 0, 0, 30);

    // R3 restart of persistence count
    step(1, 1, 0, 0, 6);
    step(1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 6);
    chk("R3 col after restart 6 edges", col, 1'b0);
    step(1, 1, 0, 0, 1);
    chk("R3 col after restart 7 edges", col, 1'b1);
    step(0, 0, 0, 0, 30);

    // R2 / R9 full duplex
    step(1, 1, 1, 0, 30);
    chk("R2 col in full duplex", col, 1'b0);
    step(1, 0, 1, 0, 3);
    chk("R9 crs tx only fd", crs, 1'b0);
    step(0, 1, 1, 0, 2);
    chk("R9 crs rx fd", crs, 1'b1);
    step(0, 0, 0, 0, 30);

    // R8 half-duplex carrier from transmit
    step(1, 0, 0, 0, 2);
    chk("R8 crs tx hd", crs, 1'b1);
    step(0, 0, 0, 0, 1);
    chk("R8 crs idle", crs, 1'b0);
    step(0, 0, 0, 0, 30);

    // R5 heartbeat timing
    step(1, 0, 0, 1, 20);
    step(0, 0, 0, 1, 10);
    chk("R5 col before pulse", col, 1'b0);
    step(0, 0, 0, 1, 1);
    chk("R5 col pulse start", col, 1'b1);
    step(0, 0, 0, 1, 9);
    chk("R5 col pulse last", col, 1'b1);
    step(0, 0, 0, 1, 1);
    chk("R5 col after pulse", col, 1'b0);
    step(0, 0, 0, 0, 10);

    // R6 heartbeat disabled
    step(1, 0, 0, 0, 10);
    step(0, 0, 0, 0, 15);
    chk("R6 no heartbeat", col, 1'b0);
    step(0, 0, 0, 0, 10);

    // R7 cancel during pulse
    step(1, 0, 0, 1, 5);
    step(0, 0, 0, 1, 12);
    chk("R7 pulse running", col, 1'b1);
    step(1, 0, 0, 0, 1);
    chk("R7 pulse cancelled", col, 1'b0);
    step(0, 0, 0, 0, 25);
    chk("R7 no pulse after disabled fall", col, 1'b0);
    // R7 cancel during delay
    step(1, 0, 0, 1, 5);
    step(0, 0, 0, 1, 5);
    step(1, 0, 0, 0, 3);
    step(0, 0, 0, 0, 15);
    chk("R7 delay cancelled", col, 1'b0);
    step(0, 0, 0, 0, 10);

    // R10 reset in the middle of a collision
    step(1, 1, 0, 0, 9);
    chk("R10 col before reset", col, 1'b1);
    rst = 1;
    step(1, 1, 0, 0, 1);
    chk("R10 col reset mid", col, 1'b0);
    chk("R10 crs reset mid", crs, 1'b0);
    rst = 0;
    step(0, 0, 0, 0, 5);

    // Random traffic compared against the model every cycle
    for (int i = 0; i < 400; i++) begin
      bit t = $urandom_range(0, 1);
      bit r = ($urandom_range(0, 3) == 0);
      bit f = ($urandom_range(0, 5) == 0);
      bit h = $urandom_range(0, 1);
      step(t, r, f, h, $urandom_range(1, 14));
    end
    step(0, 0, 0, 0, 30);
    finish();
  end

endmodule